// File: doc/BRIEF.md
# Multiframe Subchannel Register and Interrupt Unit

This block is the host register layer of the terminal side of a basic-rate ISDN line transceiver. It deals only with the 4-bit multiframe nibbles. The outgoing Q nibble is written by the host. The five incoming S-subchannel nibbles (SC1..SC5) arrive from the framer. Line coding, frame alignment and bit demodulation are done by neighbouring blocks.

On every multiframe boundary strobe, the framer marks whether multiframing is active. When it is active, the block does three things on that edge:
- It hands the held Q nibble to the framer.
- It latches all five received nibbles in one cycle.
- It evaluates the interrupt condition.

The interrupt can be set to one of three modes: off, raised when SC1 changes from one multiframe to the next, or raised every multiframe. The host clears the interrupt by reading the register that holds SC1.

Register map (8-bit data):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | control: bit 0 is the interrupt enable, bit 1 selects every-multiframe |
| 1 | read/write | outgoing Q nibble in bits 7:4 |
| 2 | read-only | SC1 in bits 7:4 |
| 3 | read-only | SC2 in bits 7:4, SC3 in bits 3:0 |
| 4 | read-only | SC4 in bits 7:4, SC5 in bits 3:0 |

Top module: `mfsub_regs`

## Requirements
- R1: After reset, the following values hold:
  - The Q register reads 8'hF0 and q_out is 4'hF.
  - q_sel and irq are 0.
  - Address 2 reads 8'hF0, addresses 3 and 4 read 8'h00, and control reads 8'h00.
- R2: On a clock edge with mf_strobe=1 and mf_enable=1, q_out takes the Q register value held before that edge, and q_sel becomes 1. A Q write in that same cycle is used at the next boundary.
- R3: If the host does not rewrite the Q register, q_out keeps its value. The same nibble is then sent again at every later boundary.
- R4: On a strobe with mf_enable=0, the following hold:
  - q_sel becomes 0 and q_out is unchanged.
  - No received nibble is captured.
  - No interrupt is raised.
- R5: rx_sub carries SCk in bits [4k-1:4k-4] for k=1..5. All five nibbles are captured on the same strobe edge, into the register layout above.
- R6: With control bit 0 equal to 0, irq is never raised, whatever control bit 1 holds.
- R7: With control bits {1,0} = 2'b01, irq is raised on a capture only when the new SC1 differs from the SC1 held before that capture. After reset, the held SC1 is 4'hF.
- R8: With control bits {1,0} = 2'b11, irq is raised on every capture.
- R9: irq is a level that stays at 1 until a read of address 2 clears it. An interrupt event on the same edge as that read leaves irq at 1.
- R10: Control and Q registers read back what was written. Writes to addresses 2, 3 and 4 have no effect.
- R11: rdata is registered: it shows the addressed register one cycle after rd_en=1, and 8'h00 when rd_en was 0 or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 3 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | registered read data |
| mf_strobe | input | 1 | multiframe boundary pulse |
| mf_enable | input | 1 | multiframing active |
| rx_sub | input | 20 | received SC1..SC5 nibbles from the framer |
| q_out | output | 4 | Q nibble handed to the framer |
| q_sel | output | 1 | 1: the framer sends q_out; 0: it uses the standard Fa wrapping pattern |
| irq | output | 1 | multiframe interrupt level |

## Verification
The bench builds the block with its default nibble width of four. The register layout, the SC1 history reset value of all ones and the nibble packing of rx_sub are therefore exercised exactly as a host would see them. With that width, only sixteen SC1 values exist. This makes it cheap to hit repeated and changed SC1 values back to back. It also makes it cheap to capture all ones straight after reset, and to line up a clearing read with an interrupt event on the same edge.

// File: rtl/mfsub_pkg.sv
package mfsub_pkg;
  localparam int NSUB = 5;
  localparam int AW   = 3;
  localparam logic [AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADR_QTX  = 3'd1;
  localparam logic [AW-1:0] ADR_SUBA = 3'd2;
  localparam logic [AW-1:0] ADR_SUBB = 3'd3;
  localparam logic [AW-1:0] ADR_SUBC = 3'd4;
endpackage

// File: rtl/mfsub_qtx.sv
module mfsub_qtx #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_q,
  input  logic [NIB_W-1:0] wnib,
  input  logic             boundary,
  input  logic             mf_on,
  output logic [NIB_W-1:0] q_reg,
  output logic [NIB_W-1:0] q_out,
  output logic             q_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_reg <= '1;
      q_out <= '1;
      q_sel <= 1'b0;
    end else begin
      if (wr_q) q_reg <= wnib;
      if (boundary) begin
        q_sel <= mf_on;
        if (mf_on) q_out <= q_reg;
      end
    end
  end
endmodule

// File: rtl/mfsub_scap.sv
module mfsub_scap #(
  parameter int NIB_W = 4,
  parameter int NSUB  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap,
  input  logic [NSUB*NIB_W-1:0] rx,
  output logic [NSUB*NIB_W-1:0] sc
);
  for (genvar k = 0; k < NSUB; k++) begin : g_slot
    localparam logic [NIB_W-1:0] RST_V = (k == 0) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (rst)      sc[k*NIB_W +: NIB_W] <= RST_V;
      else if (cap) sc[k*NIB_W +: NIB_W] <= rx[k*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/mfsub_irq.sv
module mfsub_irq #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             en,
  input  logic             every,
  input  logic [NIB_W-1:0] sc1_new,
  input  logic [NIB_W-1:0] sc1_old,
  input  logic             clr,
  output logic             irq
);
  logic evt;
  assign evt = cap && en && (every || (sc1_new != sc1_old));

  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (evt) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/mfsub_regif.sv
module mfsub_regif
  import mfsub_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DW   = 2 * NIB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  input  logic [NIB_W-1:0]      q_reg,
  input  logic [NSUB*NIB_W-1:0] sc,
  output logic                  ctl_en,
  output logic                  ctl_every,
  output logic                  wr_q,
  output logic [NIB_W-1:0]      wnib,
  output logic                  clr,
  output logic [DW-1:0]         rdata
);
  logic [DW-1:0] rd_mux;

  assign wr_q = wr_en && (addr == ADR_QTX);
  assign wnib = wdata[DW-1 -: NIB_W];
  assign clr  = rd_en && (addr == ADR_SUBA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      ctl_every <= 1'b0;
    end else if (wr_en && addr == ADR_CTRL) begin
      ctl_en    <= wdata[0];
      ctl_every <= wdata[1];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_CTRL: rd_mux = {{(DW-2){1'b0}}, ctl_every, ctl_en};
      ADR_QTX:  rd_mux = {q_reg, {NIB_W{1'b0}}};
      ADR_SUBA: rd_mux = {sc[0 +: NIB_W], {NIB_W{1'b0}}};
      ADR_SUBB: rd_mux = {sc[NIB_W +: NIB_W], sc[2*NIB_W +: NIB_W]};
      ADR_SUBC: rd_mux = {sc[3*NIB_W +: NIB_W], sc[4*NIB_W +: NIB_W]};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/mfsub_regs.sv
module mfsub_regs
  import mfsub_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int DW   = 2 * NIB_W,
  localparam int RXW  = NSUB * NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             mf_strobe,
  input  logic             mf_enable,
  input  logic [RXW-1:0]   rx_sub,
  output logic [NIB_W-1:0] q_out,
  output logic             q_sel,
  output logic             irq
);
  logic             cap;
  logic             ctl_en;
  logic             ctl_every;
  logic             wr_q;
  logic             clr;
  logic [NIB_W-1:0] wnib;
  logic [NIB_W-1:0] q_reg;
  logic [RXW-1:0]   sc_flat;

  assign cap = mf_strobe && mf_enable;

  mfsub_regif #(.NIB_W(NIB_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .q_reg(q_reg), .sc(sc_flat), .ctl_en(ctl_en),
    .ctl_every(ctl_every), .wr_q(wr_q), .wnib(wnib), .clr(clr),
    .rdata(rdata)
  );

  mfsub_qtx #(.NIB_W(NIB_W)) u_qtx (
    .clk(clk), .rst(rst), .wr_q(wr_q), .wnib(wnib), .boundary(mf_strobe),
    .mf_on(mf_enable), .q_reg(q_reg), .q_out(q_out), .q_sel(q_sel)
  );

  mfsub_scap #(.NIB_W(NIB_W), .NSUB(NSUB)) u_scap (
    .clk(clk), .rst(rst), .cap(cap), .rx(rx_sub), .sc(sc_flat)
  );

  mfsub_irq #(.NIB_W(NIB_W)) u_irq (
    .clk(clk), .rst(rst), .cap(cap), .en(ctl_en), .every(ctl_every),
    .sc1_new(rx_sub[0 +: NIB_W]), .sc1_old(sc_flat[0 +: NIB_W]),
    .clr(clr), .irq(irq)
  );
endmodule

// File: rtl/mfsub_chk.sv
module mfsub_chk
  import mfsub_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int RXW  = NSUB * NIB_W
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic             mf_strobe,
  input logic             mf_enable,
  input logic [NIB_W-1:0] q_out,
  input logic             q_sel,
  input logic             irq,
  input logic             ctl_en,
  input logic             ctl_every,
  input logic [RXW-1:0]   sc_flat
);
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(mf_strobe && mf_enable) |-> $stable(q_out)); // R3
  AST_QSEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    $past(mf_strobe) |-> (q_sel == $past(mf_enable))); // R4
  AST_SUB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(mf_strobe && mf_enable) |-> $stable(sc_flat)); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mf_strobe && mf_enable && ctl_en)); // R6
  AST_IRQ_EVERY: assert property (@(posedge clk) disable iff (rst)
    $past(mf_strobe && mf_enable && ctl_en && ctl_every) |-> irq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == ADR_SUBA && !mf_strobe) |-> !irq); // R9
endmodule

bind mfsub_regs mfsub_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .mf_strobe(mf_strobe),
  .mf_enable(mf_enable), .q_out(q_out), .q_sel(q_sel), .irq(irq),
  .ctl_en(ctl_en), .ctl_every(ctl_every), .sc_flat(sc_flat)
);

// File: tb/mfsub_regs_tb.sv
module mfsub_regs_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0, mf_strobe = 0, mf_enable = 0;
  logic [2:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [19:0] rx_sub = 0;
  logic [7:0]  rdata;
  logic [3:0]  q_out;
  logic        q_sel, irq;

  int checks = 0, fails = 0;

  // behavioural reference state
  int m_q, m_qout, m_qsel, m_irq, m_en, m_every, m_rdata;
  int m_sc[5];

  always #2 clk = ~clk;

  mfsub_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mf_strobe(mf_strobe),
    .mf_enable(mf_enable), .rx_sub(rx_sub), .q_out(q_out), .q_sel(q_sel),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rd_val(input int a);
    case (a)
      0: return m_every * 2 + m_en;
      1: return m_q * 16;
      2: return m_sc[0] * 16;
      3: return m_sc[1] * 16 + m_sc[2];
      4: return m_sc[3] * 16 + m_sc[4];
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int n_rd, rx1;
    bit capt, evt;
    if (rst) begin
      m_q = 15; m_qout = 15; m_qsel = 0; m_irq = 0; m_en = 0; m_every = 0;
      m_rdata = 0; m_sc[0] = 15;
      for (int k = 1; k < 5; k++) m_sc[k] = 0;
      return;
    end
    rx1  = int'(rx_sub[3:0]);
    capt = mf_strobe && mf_enable;
    evt  = capt && (m_en != 0) && ((m_every != 0) || rx1 != m_sc[0]);
    n_rd = rd_en ? rd_val(int'(addr)) : 0;
    if (evt) m_irq = 1;
    else if (rd_en && addr == 2) m_irq = 0;
    if (mf_strobe) begin
      m_qsel = mf_enable;
      if (mf_enable) m_qout = m_q;
    end
    if (capt) for (int k = 0; k < 5; k++) m_sc[k] = int'(rx_sub[4*k +: 4]);
    if (wr_en && addr == 0) begin m_en = int'(wdata[0]); m_every = int'(wdata[1]); end
    if (wr_en && addr == 1) m_q = int'(wdata[7:4]);
    m_rdata = n_rd;
  endtask

  // one clock: edge, model, compare all outputs, then release the strobes
  task automatic step();
    @(posedge clk);
    #1;
    model_edge();
    chk("R2 q_out", int'(q_out), m_qout);
    chk("R4 q_sel", int'(q_sel), m_qsel);
    chk("R9 irq", int'(irq), m_irq);
    chk("R11 rdata", int'(rdata), m_rdata);
    wr_en = 0; rd_en = 0; mf_strobe = 0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; addr = 3'(a); wdata = 8'(d); step();
  endtask

  task automatic rd(input int a, input string tag, input int exp);
    rd_en = 1; addr = 3'(a); step();
    chk(tag, int'(rdata), exp);
  endtask

  task automatic strobe(input logic [19:0] v, input logic mfe);
    rx_sub = v; mf_strobe = 1; mf_enable = mfe; step();
  endtask

  task automatic do_reset();
    rst = 1; repeat (3) step(); rst = 0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    chk("R1 q_out", int'(q_out), 15);
    chk("R1 irq", int'(irq), 0);
    rd(1, "R1 qtx", 8'hF0);
    rd(2, "R1 suba", 8'hF0);
    rd(3, "R1 subb", 8'h00);
    rd(0, "R1 ctrl", 8'h00);
    // R10 control read back, every multiframe mode
    wr(0, 3);
    rd(0, "R10 ctrl", 3);
    // R8 and R5: capture with per-slot values, SC1=1..SC5=5
    strobe(20'h54321, 1);
    chk("R8 irq every", int'(irq), 1);
    chk("R2 q_sel on", int'(q_sel), 1);
    rd(3, "R5 subb", 8'h23);
    rd(4, "R5 subc", 8'h45);
    rd(2, "R9 clear read", 8'h10);
    chk("R9 cleared", int'(irq), 0);
    // R2 new Q value, R3 resend
    wr(1, 8'hA0);
    strobe(20'h54321, 1);
    chk("R2 q sampled", int'(q_out), 4'hA);
    strobe(20'h54321, 1);
    chk("R3 q resent", int'(q_out), 4'hA);
    // R2 write in the same cycle as a strobe
    wr_en = 1; addr = 1; wdata = 8'h50; rx_sub = 20'h54321; mf_strobe = 1; mf_enable = 1; step();
    chk("R2 same-cycle write old", int'(q_out), 4'hA);
    strobe(20'h54321, 1);
    chk("R2 next boundary", int'(q_out), 4'h5);
    // R9 read clashing with an event keeps irq
    rd_en = 1; addr = 2; rx_sub = 20'h54321; mf_strobe = 1; mf_enable = 1; step();
    chk("R9 event wins", int'(irq), 1);
    rd(2, "R9 clear", 8'h10);
    // R7 change-only mode
    wr(0, 1);
    strobe(20'h54321, 1);
    chk("R7 same sc1", int'(irq), 0);
    strobe(20'h54327, 1);
    chk("R7 changed sc1", int'(irq), 1);
    rd(2, "R7 sc1 read", 8'h70);
    strobe(20'h99997, 1);
    chk("R7 other slots only", int'(irq), 0);
    // R6 disabled, every bit set
    wr(0, 2);
    strobe(20'h11111, 1);
    chk("R6 no irq", int'(irq), 0);
    // R4 multiframing off
    wr(0, 3);
    wr(1, 8'hC0);
    strobe(20'h22222, 0);
    chk("R4 q_sel off", int'(q_sel), 0);
    chk("R4 q held", int'(q_out), 4'h5);
    chk("R4 no irq", int'(irq), 0);
    rd(3, "R4 no capture", 8'h11);
    // R10 writes to read-only addresses ignored
    wr(2, 8'h00); wr(3, 8'hEE); wr(4, 8'hDD);
    rd(2, "R10 suba kept", 8'h10);
    rd(3, "R10 subb kept", 8'h11);
    rd(4, "R10 subc kept", 8'h11);
    // R11 unmapped address and idle read data
    rd(7, "R11 unmapped", 0);
    step();
    chk("R11 idle", int'(rdata), 0);
    // R7 history after reset is all ones
    do_reset();
    wr(0, 1);
    strobe(20'h0000F, 1);
    chk("R7 first all ones", int'(irq), 0);
    strobe(20'h00003, 1);
    chk("R7 first change", int'(irq), 1);
    step();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule